// File: doc/BRIEF.md
# Link Equalization Phase Sequencer

This block steps one serial link port through the transmitter equalization handshake that follows a speed change. A role input chooses between the upstream-facing and downstream-facing behaviour. The upstream role runs phases 0, 1, 2 and 3. The downstream role begins at phase 1. The partner's traffic arrives already decoded, as single-cycle events. Each event carries the kind of training sequence, a request flag and a preset index. Two quality flags come from an error-rate monitor: a coarse gate and a final gate.

The block drives a preset value and a request flag to be placed in outgoing training sequences. It also drives the current phase and the transmit preset this port has applied to itself. When a sequence ends it raises a one-cycle done pulse or a one-cycle fail pulse.

In phase 0 the upstream port waits for a preset from its partner, applies it and echoes it. Phase 1 holds the outgoing content constant until the coarse gate passes. In phase 2 the downstream port tunes its partner's transmitter. In phase 3 the upstream port does the tuning. A tuning port walks upward through candidate presets until the final gate passes. A per-phase cycle limit bounds every phase.

Received events have no back-pressure. `rx_valid` marks one event, and the block consumes it in the same cycle. There is no ready signal. An event that does not apply to the current phase is dropped.

Top module: `eq_phase_seq`

## Requirements
- R1: After reset the block is idle: `busy`=0, `phase`=0, `tx_req`=0, `local_preset`=0, `done`=0, `fail`=0.
- R2: A `start` pulse while idle enters phase 0 when `role_up`=1 and phase 1 when `role_up`=0, with `busy`=1 from the next cycle. A `start` pulse while busy is ignored.
- R3: In phase 0, an event with `rx_kind`=1 (second kind) and a legal preset does three things: it loads `local_preset` with that preset, makes `tx_preset` echo it, and moves the port to phase 1. Events with `rx_kind`=0 are ignored in phase 0.
- R4: A received preset above 10 is rejected. `local_preset` and the phase stay unchanged. Legal presets are 0 to 10, carried in 4 bits.
- R5: In phase 1, `tx_preset` and `tx_req` stay constant. The port moves to phase 2 only on an event seen with `q_coarse`=1.
- R6: The tuning port is the downstream role in phase 2 and the upstream role in phase 3. It drives `tx_req`=1 and sends its candidate on `tx_preset`. The candidate starts at the seed preset. The downstream role also sends the seed in phase 1. An event with `q_final`=0 advances the candidate by one, wrapping from 10 to 0.
- R7: The port being tuned drives `tx_req`=0 and echoes `local_preset`. An event with `rx_req`=1 and a legal preset loads that preset into `local_preset`.
- R8: An event with `q_final`=1 ends the phase. Phase 2 moves to phase 3, and the candidate reloads to the seed. Phase 3 returns the port to idle and gives `done`=1 for one cycle.
- R9: A tuning port that sees `q_final`=0 on its eleventh candidate ends with `fail`=1 for one cycle and returns to idle.
- R10: A phase that lasts `TIMEOUT_CYC` cycles without moving on ends with `fail`=1 and returns to idle. The count restarts on entry to every phase.
- R11: A `seed_preset` above 10 at start is replaced by 0.
- R12: `done` and `fail` are single-cycle pulses and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (taken only when idle) |
| role_up | input | 1 | 1 = upstream role, 0 = downstream role; taken at start |
| seed_preset | input | 4 | First candidate preset for tuning; taken at start |
| rx_valid | input | 1 | One decoded received training-sequence event |
| rx_kind | input | 1 | 0 = first kind, 1 = second kind |
| rx_req | input | 1 | Received event carries an equalization request |
| rx_preset | input | 4 | Preset carried by the received event |
| q_coarse | input | 1 | Error rate meets the coarse gate |
| q_final | input | 1 | Error rate meets the final target |
| busy | output | 1 | A sequence is in progress |
| phase | output | 2 | Current phase (0 when idle) |
| tx_preset | output | 4 | Preset to place in outgoing training sequences |
| tx_req | output | 1 | Outgoing sequences carry a request |
| local_preset | output | 4 | Transmit preset applied by this port |
| done | output | 1 | Successful completion pulse |
| fail | output | 1 | Failure pulse (timeout or exhaustion) |

## Verification
The bound checker watches a set of properties on every cycle:
- the phase entered on a start, set by the role;
- the frozen outgoing content during phase 1, and that phase 1 can only move on to phase 2 or end;
- the unchanged local preset after an out-of-range value;
- that the request flag is raised only in phases 2 and 3;
- that the completion and failure pulses are single-cycle, mutually exclusive, and that done comes only out of phase 3.

Some behaviour shows only in the bench's scenarios, where a behavioural model is compared against the block on every clock. These scenarios cover the candidate walk and its wrap from 10 to 0, failure on the eleventh candidate, and the exact cycle on which the timeout fires. They also show that the timeout count restarts after a phase change, that an out-of-range seed is replaced, and that starts or wrong-kind events are ignored.

// File: rtl/eqs_pkg.sv
package eqs_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_PH0  = 3'd1,
    S_PH1  = 3'd2,
    S_PH2  = 3'd3,
    S_PH3  = 3'd4
  } eqs_state_t;
endpackage

// File: rtl/eqs_phase_timer.sv
module eqs_phase_timer #(
  parameter int TIMEOUT_CYC = 1000,
  localparam int CW = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic hit
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (run)     cnt_q <= cnt_q + 1'b1;
  end

  assign hit = run && (cnt_q == CW'(TIMEOUT_CYC - 1));
endmodule

// File: rtl/eqs_preset_walker.sv
module eqs_preset_walker #(
  parameter int NUM_PRESETS = 11,
  parameter int PW = 4,
  localparam int TW = $clog2(NUM_PRESETS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] load_val,
  input  logic          step,
  output logic [PW-1:0] cand,
  output logic          last
);
  logic [TW-1:0] tries_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cand    <= '0;
      tries_q <= '0;
    end else if (load) begin
      cand    <= load_val;
      tries_q <= '0;
    end else if (step) begin
      cand    <= (cand == PW'(NUM_PRESETS - 1)) ? '0 : cand + 1'b1;
      tries_q <= tries_q + 1'b1;
    end
  end

  assign last = (tries_q == TW'(NUM_PRESETS - 1));
endmodule

// File: rtl/eq_phase_seq.sv
module eq_phase_seq
  import eqs_pkg::*;
#(
  parameter int NUM_PRESETS = 11,
  parameter int PW = 4,
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          role_up,
  input  logic [PW-1:0] seed_preset,
  input  logic          rx_valid,
  input  logic          rx_kind,
  input  logic          rx_req,
  input  logic [PW-1:0] rx_preset,
  input  logic          q_coarse,
  input  logic          q_final,
  output logic          busy,
  output logic [1:0]    phase,
  output logic [PW-1:0] tx_preset,
  output logic          tx_req,
  output logic [PW-1:0] local_preset,
  output logic          done,
  output logic          fail
);
  eqs_state_t    st_q, st_d;
  logic          role_q, role_d;
  logic [PW-1:0] seed_q, seed_d, loc_q, loc_d, seed_ok, walk_val, cand;
  logic          done_d, fail_d, walk_load, walk_step, walk_last, tmo_hit;
  logic          rx_legal, seed_legal, tuner, tuned;

  assign rx_legal   = int'(rx_preset) < NUM_PRESETS;
  assign seed_legal = int'(seed_preset) < NUM_PRESETS;
  assign seed_ok    = seed_legal ? seed_preset : '0;

  assign tuner = (st_q == S_PH2 && !role_q) || (st_q == S_PH3 && role_q);
  assign tuned = (st_q == S_PH2 && role_q)  || (st_q == S_PH3 && !role_q);

  eqs_phase_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (st_d != st_q),
    .run     (st_q != S_IDLE),
    .hit     (tmo_hit)
  );

  eqs_preset_walker #(.NUM_PRESETS(NUM_PRESETS), .PW(PW)) u_walker (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (walk_load),
    .load_val (walk_val),
    .step     (walk_step),
    .cand     (cand),
    .last     (walk_last)
  );

  always_comb begin
    st_d      = st_q;
    role_d    = role_q;
    seed_d    = seed_q;
    loc_d     = loc_q;
    done_d    = 1'b0;
    fail_d    = 1'b0;
    walk_load = 1'b0;
    walk_step = 1'b0;
    walk_val  = seed_q;
    unique case (st_q)
      S_IDLE: begin
        if (start) begin
          role_d    = role_up;
          seed_d    = seed_ok;
          walk_load = 1'b1;
          walk_val  = seed_ok;
          st_d      = role_up ? S_PH0 : S_PH1;
        end
      end
      S_PH0: begin
        if (rx_valid && rx_kind && rx_legal) begin
          loc_d = rx_preset;
          st_d  = S_PH1;
        end
      end
      S_PH1: begin
        if (rx_valid && q_coarse) st_d = S_PH2;
      end
      S_PH2, S_PH3: begin
        if (rx_valid) begin
          if (q_final) begin
            if (st_q == S_PH2) begin
              st_d      = S_PH3;
              walk_load = 1'b1;
            end else begin
              st_d   = S_IDLE;
              done_d = 1'b1;
            end
          end else if (tuner) begin
            if (walk_last) begin
              st_d   = S_IDLE;
              fail_d = 1'b1;
            end else begin
              walk_step = 1'b1;
            end
          end else if (tuned && rx_req && rx_legal) begin
            loc_d = rx_preset;
          end
        end
      end
      default: st_d = S_IDLE;
    endcase
    if (st_q != S_IDLE && st_d == st_q && tmo_hit) begin
      st_d   = S_IDLE;
      fail_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      role_q <= 1'b0;
      seed_q <= '0;
      loc_q  <= '0;
      done   <= 1'b0;
      fail   <= 1'b0;
    end else begin
      st_q   <= st_d;
      role_q <= role_d;
      seed_q <= seed_d;
      loc_q  <= loc_d;
      done   <= done_d;
      fail   <= fail_d;
    end
  end

  always_comb begin
    unique case (st_q)
      S_PH0:   phase = 2'd0;
      S_PH1:   phase = 2'd1;
      S_PH2:   phase = 2'd2;
      S_PH3:   phase = 2'd3;
      default: phase = 2'd0;
    endcase
  end

  assign busy         = (st_q != S_IDLE);
  assign tx_req       = tuner;
  assign tx_preset    = (tuner || (st_q == S_PH1 && !role_q)) ? cand : loc_q;
  assign local_preset = loc_q;
endmodule

// File: rtl/eqs_checker.sv
module eqs_checker #(
  parameter int PW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          role_up,
  input logic          rx_valid,
  input logic [PW-1:0] rx_preset,
  input logic          busy,
  input logic [1:0]    phase,
  input logic [PW-1:0] tx_preset,
  input logic          tx_req,
  input logic [PW-1:0] local_preset,
  input logic          done,
  input logic          fail
);
  // R2: start while idle enters the phase set by the role
  p_start_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && phase == ($past(role_up) ? 2'd0 : 2'd1)));

  // R4: an out-of-range received preset leaves the applied preset alone
  p_reject_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rx_valid && rx_preset > PW'(10)) |=> $stable(local_preset));

  // R5: outgoing content is frozen within phase 1
  p_ph1_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase == 2'd1 && $past(busy && phase == 2'd1)) |->
      ($stable(tx_preset) && $stable(tx_req)));

  // R5: phase 1 can only stay, move to phase 2 or end
  p_ph1_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase == 2'd1) |=> (!busy || phase == 2'd1 || phase == 2'd2));

  // R6: requests only come from a tuning phase
  p_req_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> (busy && phase >= 2'd2));

  // R8: completion only comes out of phase 3
  p_done_from_ph3_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy) && $past(phase) == 2'd3));

  // R12: completion and failure are exclusive single-cycle pulses
  p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_fail_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> !fail);
endmodule

bind eq_phase_seq eqs_checker #(.PW(PW)) u_chk (.*);

// File: tb/eq_phase_seq_bench.sv
module eq_phase_seq_bench;
  localparam int TMO = 24;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, role_up = 0, rx_valid = 0, rx_kind = 0, rx_req = 0;
  logic q_coarse = 0, q_final = 0;
  logic [3:0] seed_preset = 0, rx_preset = 0;
  logic busy, tx_req, done, fail;
  logic [1:0] phase;
  logic [3:0] tx_preset, local_preset;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  eq_phase_seq #(.NUM_PRESETS(11), .PW(4), .TIMEOUT_CYC(TMO)) u_eq_phase_seq (.*);

  // Behavioural reference: st 0 idle, 1..4 = phase 0..3
  int m_st = 0, m_role = 0, m_seed = 0, m_cand = 0, m_tries = 0, m_cnt = 0, m_loc = 0;
  int m_done = 0, m_fail = 0;
  always @(posedge clk) begin
    int nxt;
    bit tun;
    m_done = 0; m_fail = 0;
    if (!rst_n) begin
      m_st = 0; m_role = 0; m_seed = 0; m_cand = 0; m_tries = 0; m_cnt = 0; m_loc = 0;
    end else begin
      nxt = m_st;
      tun = (m_st == 3) ? (m_role == 0) : (m_st == 4 && m_role == 1);
      if (m_st == 0) begin
        if (start) begin
          m_role = role_up; m_seed = (seed_preset > 10) ? 0 : seed_preset;
          m_cand = m_seed; m_tries = 0; nxt = role_up ? 1 : 2;
        end
      end else if (m_st == 1) begin
        if (rx_valid && rx_kind && rx_preset <= 10) begin m_loc = rx_preset; nxt = 2; end
      end else if (m_st == 2) begin
        if (rx_valid && q_coarse) nxt = 3;
      end else if (rx_valid) begin
        if (q_final) begin
          if (m_st == 3) begin nxt = 4; m_cand = m_seed; m_tries = 0; end
          else begin nxt = 0; m_done = 1; end
        end else if (tun) begin
          if (m_tries == 10) begin nxt = 0; m_fail = 1; end
          else begin m_cand = (m_cand == 10) ? 0 : m_cand + 1; m_tries++; end
        end else if (rx_req && rx_preset <= 10) m_loc = rx_preset;
      end
      if (m_st != 0) begin
        if (nxt == m_st) begin
          if (m_cnt == TMO - 1) begin nxt = 0; m_fail = 1; m_cnt = 0; end
          else m_cnt++;
        end else m_cnt = 0;
      end else m_cnt = 0;
      m_st = nxt;
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the model on every clock, mid-cycle
  always @(negedge clk) if (rst_n) begin
    bit tun;
    tun = (m_st == 3) ? (m_role == 0) : (m_st == 4 && m_role == 1);
    chk(busy, m_st != 0, "R2 busy");
    chk(phase, (m_st != 0) ? m_st - 1 : 0, "R2 phase");
    chk(tx_req, tun, "R6 tx_req");
    chk(tx_preset, (tun || (m_st == 2 && m_role == 0)) ? m_cand : m_loc, "R6 tx_preset");
    chk(local_preset, m_loc, "R7 local_preset");
    chk(done, m_done, "R8 done");
    chk(fail, m_fail, "R10 fail");
    chk(done && fail, 0, "R12 exclusive");
  end

  task automatic drive(input bit st, input bit v, input bit k, input bit rq,
                       input int p, input bit cq, input bit fq);
    start = st; rx_valid = v; rx_kind = k; rx_req = rq; rx_preset = p[3:0];
    q_coarse = cq; q_final = fq;
    @(posedge clk); #2;
    start = 0; rx_valid = 0; rx_kind = 0; rx_req = 0; rx_preset = 0;
    q_coarse = 0; q_final = 0;
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic look;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2; rst_n = 1;
    look;
    chk(busy, 0, "R1 busy"); chk(phase, 0, "R1 phase"); chk(tx_req, 0, "R1 tx_req");
    chk(local_preset, 0, "R1 local"); chk(done, 0, "R1 done"); chk(fail, 0, "R1 fail");

    // Upstream full run
    role_up = 1; seed_preset = 3;
    drive(1, 0, 0, 0, 0, 0, 0); look; chk(phase, 0, "R2 up enters 0"); chk(busy, 1, "R2 busy");
    drive(0, 1, 0, 0, 5, 0, 0); look; chk(phase, 0, "R3 first kind ignored"); chk(local_preset, 0, "R3 local kept");
    drive(0, 1, 1, 0, 12, 0, 0); look; chk(phase, 0, "R4 bad preset stays"); chk(local_preset, 0, "R4 local kept");
    drive(0, 1, 1, 0, 7, 0, 0); look; chk(phase, 1, "R3 to phase 1");
    chk(local_preset, 7, "R3 applied"); chk(tx_preset, 7, "R3 echo");
    drive(1, 0, 0, 0, 0, 0, 0); look; chk(phase, 1, "R2 start ignored");
    drive(0, 1, 0, 0, 2, 0, 0); look; chk(phase, 1, "R5 no coarse"); chk(tx_preset, 7, "R5 stable");
    drive(0, 1, 0, 0, 0, 1, 0); look; chk(phase, 2, "R5 coarse exit");
    chk(tx_req, 0, "R7 tuned no req");
    drive(0, 1, 0, 1, 4, 0, 0); look; chk(local_preset, 4, "R7 apply request");
    drive(0, 1, 0, 1, 11, 0, 0); look; chk(local_preset, 4, "R4 reject in tuning");
    drive(0, 1, 0, 0, 0, 0, 1); look; chk(phase, 3, "R8 phase 3");
    chk(tx_req, 1, "R6 up tunes in 3"); chk(tx_preset, 3, "R6 seed candidate");
    drive(0, 1, 0, 0, 0, 0, 0); look; chk(tx_preset, 4, "R6 step");
    drive(0, 1, 0, 0, 0, 0, 1); look; chk(done, 1, "R8 done"); chk(busy, 0, "R8 idle");
    look; chk(done, 0, "R12 done single");

    // Downstream run with wrap
    role_up = 0; seed_preset = 9;
    drive(1, 0, 0, 0, 0, 0, 0); look; chk(phase, 1, "R2 down enters 1"); chk(tx_preset, 9, "R6 seed sent");
    drive(0, 1, 0, 0, 0, 1, 0); look; chk(tx_req, 1, "R6 down tunes in 2");
    drive(0, 1, 0, 0, 0, 0, 0); look; chk(tx_preset, 10, "R6 step");
    drive(0, 1, 0, 0, 0, 0, 0); look; chk(tx_preset, 0, "R6 wrap");
    drive(0, 1, 0, 0, 0, 0, 1); look; chk(phase, 3, "R8 to 3"); chk(tx_req, 0, "R7 tuned in 3");
    drive(0, 1, 0, 1, 2, 0, 0); look; chk(local_preset, 2, "R7 apply");
    drive(0, 1, 0, 0, 0, 0, 1); look; chk(done, 1, "R8 down done");

    // Exhaustion with a sanitized seed
    seed_preset = 15;
    drive(1, 0, 0, 0, 0, 0, 0); look; chk(tx_preset, 0, "R11 seed replaced");
    drive(0, 1, 0, 0, 0, 1, 0);
    for (int i = 0; i < 10; i++) drive(0, 1, 0, 0, 0, 0, 0);
    look; chk(busy, 1, "R9 still tuning"); chk(tx_preset, 10, "R9 last candidate");
    drive(0, 1, 0, 0, 0, 0, 0); look; chk(fail, 1, "R9 fail"); chk(busy, 0, "R9 idle");

    // Timeout in phase 0
    role_up = 1;
    drive(1, 0, 0, 0, 0, 0, 0); idle(TMO - 1); look; chk(busy, 1, "R10 before limit");
    idle(1); look; chk(fail, 1, "R10 timeout"); chk(busy, 0, "R10 idle");

    // Timeout count restarts on phase entry
    drive(1, 0, 0, 0, 0, 0, 0); idle(20);
    drive(0, 1, 1, 0, 6, 0, 0); idle(TMO - 1); look; chk(phase, 1, "R10 restarted");
    chk(busy, 1, "R10 restarted busy");
    idle(1); look; chk(fail, 1, "R10 phase 1 timeout");
    idle(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule